// File: doc/BRIEF.md
# Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. A character is written into a single-entry holding register. When the output stage is free, the character moves into a shift register. The line then carries a low start bit, the data field least significant bit first, an optional parity bit and one or two high stop bits. Between frames the line rests high.

Bit timing comes from an enable pulse that runs at sixteen times the bit rate. Every bit lasts sixteen of these pulses, however many clock cycles separate them. The frame format is chosen at run time: 7 or 8 data bits, parity present or absent, even or odd parity, and one or two stop bits. The format is captured as each character enters the shift register.

A second character can wait in the holding register while the first one shifts out, so frames follow each other with no idle gap. Two flags report progress. One says the holding register is empty. The other says the line has finished its last frame and nothing is waiting.

Top module: `serial_frame_tx`

## Requirements
- R1: While rst_n is low, txd is 1, hold_empty is 1 and tx_end is 1.
- R2: Whenever no frame is in progress, txd is 1.
- R3: A frame opens with a start bit at txd=0. The start bit and every later bit last exactly 16 tick16 pulses, counted from the clock edge on which that bit began.
- R4: Data bits follow the start bit least significant bit first. With fmt_short=0 there are 8 bits (wr_data[7:0]). With fmt_short=1 there are 7 bits (wr_data[6:0]), and wr_data[7] has no effect on the line.
- R5: With fmt_par_on=1, one parity bit follows the data, computed over the active data bits only. fmt_par_odd=0 selects even parity: the number of ones in data plus parity is even. fmt_par_odd=1 selects odd parity: that number is odd. With fmt_par_on=0 no parity bit is sent.
- R6: The frame ends with high stop bits: two when fmt_dual_stop=1, one when fmt_dual_stop=0.
- R7: The format inputs are sampled on the clock edge where the character moves into the shift register. Later changes to them do not alter that frame.
- R8: A write (wr_valid=1) is accepted only when hold_empty=1, and hold_empty reads 0 from the next cycle. A write made while hold_empty=0 is dropped: the held character is kept and the dropped value is never sent.
- R9: A character written while the line is idle moves into the shift register on the clock edge after the write edge. On that edge hold_empty returns to 1 and txd drops to 0.
- R10: If the holding register is full when the last stop bit ends, the next start bit begins on the very next clock cycle, with no high gap.
- R11: tx_end becomes 1 when the last stop bit ends with the holding register empty. An accepted write clears it on the edge where the write is taken, and this takes priority over setting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| fmt_short | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_par_on | input | 1 | 1: append a parity bit |
| fmt_par_odd | input | 1 | 1: odd parity, 0: even parity |
| fmt_dual_stop | input | 1 | 1: two stop bits, 0: one |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Holding register can take a character |
| tx_end | output | 1 | Line idle with nothing waiting |

## Verification
The bench builds the block with its defaults: an 8-bit holding register and 16 ticks per bit. This brings both the 7-bit and 8-bit data fields within reach, together with every parity and stop combination.

The tick16 enable is driven three ways: on every cycle, on every third cycle, and on random cycles. This confirms that bit length follows the tick count and not the clock count.

Random write spacing exercises several paths: idle starts, frames sent back to back, writes dropped while the holding register is full, and format changes in the middle of a frame.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic short_word;
        logic par_on;
        logic par_odd;
        logic dual_stop;
    } frame_fmt_t;

endpackage

// File: rtl/sft_hold_reg.sv
module sft_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              wr_ok
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d   = h_q;
        wr_ok = wr_valid && !h_q.full;
        if (take) begin
            h_d.full = 1'b0;
        end
        if (wr_ok) begin
            h_d.full = 1'b1;
            h_d.data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign full = h_q.full;
    assign data = h_q.data;

    // R8: a write to an empty register fills it
    p_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !full |=> full);

    // R8: a full register that is not drained keeps its character
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full && !take |=> full && $stable(data));

    // the shifter only drains a full register
    p_take_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick16,
    output logic bit_done
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        bit_done = run && tick16 && (cnt_q == LAST);
        if (restart || !run) begin
            cnt_d = '0;
        end else if (tick16) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3: the count moves only on ticks
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run && !tick16 && !restart |=> $stable(cnt_q));

    // R3: a restart begins a fresh bit period
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> cnt_q == '0);

endmodule

// File: rtl/sft_shifter.sv
module sft_shifter
    import sft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_fmt_t        fmt_in,
    input  logic              bit_done,
    output logic              load,
    output logic              busy,
    output logic              txd,
    output logic              frame_end
);

    localparam int LEFT_W = $clog2(DATA_W);
    localparam logic [LEFT_W-1:0] LEFT_FULL  = LEFT_W'(DATA_W - 1);
    localparam logic [LEFT_W-1:0] LEFT_SHORT = LEFT_W'(DATA_W - 2);

    typedef struct packed {
        phase_e            ph;
        logic [DATA_W-1:0] sh;
        logic [LEFT_W-1:0] left;
        logic              par;
        frame_fmt_t        fmt;
        logic              second;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        load      = 1'b0;
        frame_end = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (hold_full) begin
                    load = 1'b1;
                end
            end
            PH_START: begin
                if (bit_done) begin
                    s_d.ph = PH_DATA;
                end
            end
            PH_DATA: begin
                if (bit_done) begin
                    s_d.par = s_q.par ^ s_q.sh[0];
                    s_d.sh  = s_q.sh >> 1;
                    if (s_q.left == '0) begin
                        s_d.ph = s_q.fmt.par_on ? PH_PARITY : PH_STOP;
                    end else begin
                        s_d.left = s_q.left - 1'b1;
                    end
                end
            end
            PH_PARITY: begin
                if (bit_done) begin
                    s_d.ph = PH_STOP;
                end
            end
            PH_STOP: begin
                if (bit_done) begin
                    if (s_q.fmt.dual_stop && !s_q.second) begin
                        s_d.second = 1'b1;
                    end else begin
                        frame_end = 1'b1;
                        if (hold_full) begin
                            load = 1'b1;
                        end else begin
                            s_d.ph = PH_IDLE;
                        end
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (load) begin
            s_d.ph     = PH_START;
            s_d.sh     = hold_data;
            s_d.fmt    = fmt_in;
            s_d.left   = fmt_in.short_word ? LEFT_SHORT : LEFT_FULL;
            s_d.par    = 1'b0;
            s_d.second = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, sh: '0, left: '0, par: 1'b0,
                     fmt: '0, second: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        unique case (s_q.ph)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = s_q.sh[0];
            PH_PARITY: txd = s_q.par ^ s_q.fmt.par_odd;
            default:   txd = 1'b1;
        endcase
    end

    assign busy = (s_q.ph != PH_IDLE);

    // R9: a load puts the start bit on the line at once
    p_load_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !txd && busy);

    // R10: a waiting character follows the last stop bit without a gap
    p_back_to_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && hold_full |=> !txd);

    // R7: the captured format stays fixed for the whole frame
    p_fmt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> $stable(s_q.fmt));

    // R3: the phase advances only at a bit boundary or a load
    p_step_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_done && !load |=> $stable(s_q.ph));

    // R6: stop bits are high
    p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> txd);

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              fmt_short,
    input  logic              fmt_par_on,
    input  logic              fmt_par_odd,
    input  logic              fmt_dual_stop,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_end
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              wr_ok;
    logic              load;
    logic              busy;
    logic              bit_done;
    logic              frame_end;
    frame_fmt_t        fmt_now;
    logic              end_d, end_q;

    assign fmt_now = '{short_word: fmt_short, par_on: fmt_par_on,
                       par_odd: fmt_par_odd, dual_stop: fmt_dual_stop};

    sft_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (load),
        .full     (hold_full),
        .data     (hold_data),
        .wr_ok    (wr_ok)
    );

    sft_bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .restart  (load),
        .tick16   (tick16),
        .bit_done (bit_done)
    );

    sft_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .fmt_in    (fmt_now),
        .bit_done  (bit_done),
        .load      (load),
        .busy      (busy),
        .txd       (txd),
        .frame_end (frame_end)
    );

    always_comb begin
        end_d = end_q;
        if (frame_end && !hold_full) begin
            end_d = 1'b1;
        end
        if (wr_ok) begin
            end_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b1;
        end else begin
            end_q <= end_d;
        end
    end

    assign hold_empty = !hold_full;
    assign tx_end     = end_q;

    // R2: a finished line rests at mark
    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end |-> txd);

    // R11: end of the last frame with nothing waiting raises the flag
    p_end_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && hold_empty && !wr_valid |=> tx_end);

    // R11: an accepted write clears the flag
    p_end_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && hold_empty |=> !tx_end && !hold_empty);

endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic       fmt_short, fmt_par_on, fmt_par_odd, fmt_dual_stop;
    logic       wr_valid;
    logic [7:0] wr_data;
    logic       txd, hold_empty, tx_end;

    always #2 clk = ~clk;

    serial_frame_tx u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .fmt_short     (fmt_short),
        .fmt_par_on    (fmt_par_on),
        .fmt_par_odd   (fmt_par_odd),
        .fmt_dual_stop (fmt_dual_stop),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .txd           (txd),
        .hold_empty    (hold_empty),
        .tx_end        (tx_end)
    );

    int         checks   = 0;
    int         errors   = 0;
    int         accepted = 0;
    int         started  = 0;
    int         tick_mode = 0;
    logic [7:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] actual,
                       input logic [31:0] expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    function automatic logic [11:0] frame_vec(input logic [7:0] d, input logic sh,
                                              input logic pe, input logic po);
        logic [11:0] v;
        int          n;
        logic        p;
        v    = '1;
        v[0] = 1'b0;
        n    = sh ? 7 : 8;
        p    = 1'b0;
        for (int i = 0; i < n; i++) begin
            v[1+i] = d[i];
            p      = p ^ d[i];
        end
        if (pe) v[1+n] = p ^ po;
        return v;
    endfunction

    function automatic int frame_len(input logic sh, input logic pe, input logic ds);
        return 1 + (sh ? 7 : 8) + (pe ? 1 : 0) + (ds ? 2 : 1);
    endfunction

    function automatic string req_of(input int idx, input logic sh, input logic pe);
        int n;
        n = sh ? 7 : 8;
        if (idx == 0) return "R3 start bit";
        if (idx <= n) return "R4 data bit";
        if (pe && idx == n + 1) return "R5 parity bit";
        return "R6 stop bit";
    endfunction

    // tick16 generator
    initial begin
        int phase;
        phase  = 0;
        tick16 = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            phase = (phase + 1) % 3;
            case (tick_mode)
                0:       tick16 = 1'b1;
                1:       tick16 = (($urandom % 2) == 0);
                default: tick16 = (phase == 0);
            endcase
        end
    end

    // line monitor
    bit          in_frame = 0;
    bit          post = 0, pend = 0, wr_end = 0;
    logic [11:0] cv;
    int          cl, idx, cnt;
    bit          bad;
    logic        badval;
    logic [3:0]  snap = 4'b0;
    logic [3:0]  cfmt;
    logic [7:0]  cur_d;

    always @(negedge clk) begin
        if (rst_n) begin
            if (post) begin
                post = 0;
                if (pend) begin
                    chk(txd == 1'b0, "R10 next start bit without gap", txd, 0);
                end else begin
                    chk(txd == 1'b1, "R2 line high after frame", txd, 1);
                    chk(tx_end == !wr_end, "R11 tx_end after last stop", tx_end, !wr_end);
                end
            end
            if (!in_frame && txd == 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 frame without accepted write", 1, 0);
                    cur_d = 8'h00;
                end else begin
                    cur_d = exp_q.pop_front();
                end
                started++;
                cfmt     = snap;
                cv       = frame_vec(cur_d, cfmt[3], cfmt[2], cfmt[1]);
                cl       = frame_len(cfmt[3], cfmt[2], cfmt[0]);
                idx      = 0;
                cnt      = 0;
                bad      = 0;
                in_frame = 1;
            end
            if (in_frame) begin
                if (txd !== cv[idx] && !bad) begin
                    bad    = 1;
                    badval = txd;
                end
                if (tick16) begin
                    cnt++;
                    if (cnt == 16) begin
                        checks++;
                        if (bad) begin
                            errors++;
                            $display("FAIL %s index %0d of char %0h actual=%0b expected=%0b",
                                     req_of(idx, cfmt[3], cfmt[2]), idx, cur_d, badval, cv[idx]);
                        end
                        idx++;
                        cnt = 0;
                        bad = 0;
                        if (idx == cl) begin
                            in_frame = 0;
                            post     = 1;
                            pend     = (accepted > started);
                            wr_end   = wr_valid && hold_empty;
                        end
                    end
                end
            end
        end
        snap = {fmt_short, fmt_par_on, fmt_par_odd, fmt_dual_stop};
    end

    task automatic set_fmt(input logic [3:0] f);
        @(posedge clk);
        #1;
        {fmt_short, fmt_par_on, fmt_par_odd, fmt_dual_stop} = f;
    endtask

    task automatic put(input logic [7:0] d);
        bit ok;
        @(posedge clk);
        #1;
        wr_valid = 1'b1;
        wr_data  = d;
        ok       = hold_empty;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        if (ok) begin
            exp_q.push_back(d);
            accepted++;
        end
    endtask

    task automatic wait_room();
        do @(negedge clk); while (!hold_empty);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_q.size() != 0 || in_frame || post || !tx_end);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n    = 1'b0;
        wr_valid = 1'b0;
        wr_data  = 8'h00;
        {fmt_short, fmt_par_on, fmt_par_odd, fmt_dual_stop} = 4'b0000;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
        chk(tx_end == 1'b1, "R1 reset tx_end", tx_end, 1);
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9: write into an idle line, 8 data bits, no parity, one stop
        tick_mode = 0;
        put(8'hA5);
        @(negedge clk);
        chk(hold_empty == 1'b0, "R8 hold_empty falls after write", hold_empty, 0);
        chk(tx_end == 1'b0, "R11 write clears tx_end", tx_end, 0);
        chk(txd == 1'b1, "R9 line still high one cycle after write", txd, 1);
        @(negedge clk);
        chk(txd == 1'b0, "R9 start bit on transfer edge", txd, 0);
        chk(hold_empty == 1'b1, "R9 hold_empty back on transfer edge", hold_empty, 1);

        // R8: fill the holding register, then a dropped write; R10 gapless follow-on
        put(8'h3C);
        put(8'hFF);
        @(negedge clk);
        chk(hold_empty == 1'b0, "R8 dropped write keeps register full", hold_empty, 0);
        wait_idle();

        // R4 R5 R6: 7-bit even parity two stops with bit 7 set, then R7 change mid-frame
        set_fmt(4'b1101);
        put(8'hFF);
        wait_room();
        set_fmt(4'b0110);
        put(8'h80);
        set_fmt(4'b1011);
        wait_idle();

        // R3: sparse ticks, every third cycle
        tick_mode = 2;
        set_fmt(4'b0111);
        put(8'h01);
        put(8'hFE);
        wait_idle();

        // random traffic
        for (int n = 0; n < 60; n++) begin
            if (n % 10 == 0) tick_mode = $urandom % 3;
            wait_room();
            set_fmt(4'($urandom));
            if (($urandom % 5) == 0) wait_idle();
            put(8'($urandom));
            if (($urandom % 4) == 0) put(8'($urandom));
        end
        wait_idle();
        @(negedge clk);
        chk(txd == 1'b1 && hold_empty == 1'b1, "R2 final idle line", {txd, hold_empty}, 2'b11);
        chk(started == accepted, "R8 every accepted character sent", started, accepted);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule